// File: doc/BRIEF.md
# Run-length expanding byte decompressor

This block sits behind the receive side of an enhanced parallel port link. It turns a tagged item stream into a plain byte stream. Each input item carries a tag that marks it as a command item or a data item. A command item with its top bit clear is a repeat count. The count arms the expander, and the next data item is then emitted count+1 times. A command item with its top bit set is a channel address. It is passed to a one-cycle side strobe and does not disturb the expander.

Input and output both use valid/ready handshakes. While a run is being replayed, the input is held off. The output keeps its byte steady under backpressure. Compressed data is only expanded here: the block never creates counts.

Top module: `rle_expander`

## Requirements
- R1: When a count item N is followed by a data item, exactly N+1 copies of that data byte leave on the output, in order, before any later byte.
- R2: A count of 0 makes the following data byte appear exactly once.
- R3: A count of 127 makes the following data byte appear 128 times.
- R4: A data item accepted while no count is pending is emitted once.
- R5: If a second count item arrives before any data item, it replaces the earlier count. Only the newer count governs the next data byte.
- R6: A command item with bit 7 set raises chan_valid_o for exactly one cycle, in the cycle after acceptance, with chan_addr_o equal to its bits 6:0. It produces no output byte and leaves a pending count intact.
- R7: in_ready_o is high when no output byte is waiting, or when the last copy of a run is being taken in this cycle. Otherwise it is low.
- R8: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_byte_o keeps its value into the next cycle.
- R9: Reset (rst_ni low) clears any pending count and any run in progress. After reset, out_valid_o and chan_valid_o are low and in_ready_o is high.
- R10: A pending count applies only to the data item that directly consumes it. The following data item with no new count is emitted once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input item valid |
| in_ready_o | output | 1 | Input item accepted when high with valid |
| in_is_cmd_i | input | 1 | 1 = command item, 0 = data item |
| in_byte_i | input | 8 | Item payload |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream ready |
| out_byte_o | output | 8 | Expanded byte |
| chan_valid_o | output | 1 | One-cycle channel-address strobe |
| chan_addr_o | output | 7 | Channel address (command bits 6:0) |

## Verification
The assertions assume that the upstream source holds an item and its tag unchanged while in_valid_i is high and the item has not been taken. They also assume that out_ready_i is a free choice of the sink in every cycle. The stimulus keeps an offered item fixed until the model sees a handshake, and draws out_ready_i at random each cycle from a settable probability. A queue model of the expected bytes is compared against the outputs every cycle. Directed runs cover counts of 0 and 127, replaced counts, interleaved channel items and reset in mid-run.

// File: rtl/rle_pkg.sv
package rle_pkg;
  typedef enum logic [1:0] {
    KIND_DATA  = 2'd0,
    KIND_COUNT = 2'd1,
    KIND_CHAN  = 2'd2
  } item_kind_e;
endpackage

// File: rtl/rle_item_decode.sv
module rle_item_decode
  import rle_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int PAY_W = DATA_W - 1
) (
  input  logic              is_cmd_i,
  input  logic [DATA_W-1:0] byte_i,
  output item_kind_e        kind_o,
  output logic [PAY_W-1:0]  payload_o
);
  always_comb begin
    payload_o = byte_i[PAY_W-1:0];
    if (!is_cmd_i)              kind_o = KIND_DATA;
    else if (byte_i[DATA_W-1])  kind_o = KIND_CHAN;
    else                        kind_o = KIND_COUNT;
  end
endmodule

// File: rtl/rle_pend_reg.sv
module rle_pend_reg #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             consume_i,
  output logic             pend_vld_o,
  output logic [CNT_W-1:0] pend_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vld_o <= 1'b0;
      pend_cnt_o <= '0;
    end else if (load_i) begin
      pend_vld_o <= 1'b1;
      pend_cnt_o <= cnt_i;  // newer count overwrites
    end else if (consume_i) begin
      pend_vld_o <= 1'b0;
      pend_cnt_o <= '0;
    end
  end
endmodule

// File: rtl/rle_run_out.sv
module rle_run_out #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [CNT_W-1:0]  reps_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_byte_o,
  output logic              last_o
);
  logic [CNT_W-1:0] rem_q;

  assign last_o = (rem_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_byte_o  <= '0;
      rem_q       <= '0;
    end else if (start_i) begin
      out_valid_o <= 1'b1;
      out_byte_o  <= byte_i;
      rem_q       <= reps_i;  // copies still owed after the current one
    end else if (out_valid_o && out_ready_i) begin
      if (last_o) out_valid_o <= 1'b0;
      else        rem_q       <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/rle_expander.sv
module rle_expander
  import rle_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              in_is_cmd_i,
  input  logic [DATA_W-1:0] in_byte_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_byte_o,
  output logic              chan_valid_o,
  output logic [CNT_W-1:0]  chan_addr_o
);
  item_kind_e       kind;
  logic [CNT_W-1:0] payload;
  logic             fire_in;
  logic             pend_vld;
  logic [CNT_W-1:0] pend_cnt;
  logic             run_last;
  logic             start_run;

  rle_item_decode #(.DATA_W(DATA_W)) u_decode (
    .is_cmd_i  (in_is_cmd_i),
    .byte_i    (in_byte_i),
    .kind_o    (kind),
    .payload_o (payload)
  );

  assign in_ready_o = !out_valid_o || (run_last && out_ready_i);
  assign fire_in    = in_valid_i && in_ready_o;
  assign start_run  = fire_in && (kind == KIND_DATA);

  rle_pend_reg #(.CNT_W(CNT_W)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (fire_in && (kind == KIND_COUNT)),
    .cnt_i      (payload),
    .consume_i  (start_run),
    .pend_vld_o (pend_vld),
    .pend_cnt_o (pend_cnt)
  );

  rle_run_out #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_run),
    .byte_i      (in_byte_i),
    .reps_i      (pend_vld ? pend_cnt : '0),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_byte_o  (out_byte_o),
    .last_o      (run_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_valid_o <= 1'b0;
      chan_addr_o  <= '0;
    end else begin
      chan_valid_o <= fire_in && (kind == KIND_CHAN);
      if (fire_in && (kind == KIND_CHAN)) chan_addr_o <= payload;
    end
  end
endmodule

// File: rtl/rle_expander_chk.sv
module rle_expander_chk #(
  parameter int DATA_W = 8,
  localparam int CNT_W = DATA_W - 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              in_is_cmd_i,
  input logic [DATA_W-1:0] in_byte_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [DATA_W-1:0] out_byte_o,
  input logic              chan_valid_o,
  input logic [CNT_W-1:0]  chan_addr_o
);
  logic fire_chan, fire_data;
  assign fire_chan = in_valid_i && in_ready_o && in_is_cmd_i && in_byte_i[DATA_W-1];
  assign fire_data = in_valid_i && in_ready_o && !in_is_cmd_i;

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_byte_o));

  assert_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  assert_idle_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

  assert_chan_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_chan |=> chan_valid_o && (chan_addr_o == $past(in_byte_i[CNT_W-1:0])));

  assert_chan_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_chan |=> !chan_valid_o);

  assert_data_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_data |=> out_valid_o && (out_byte_o == $past(in_byte_i)));
endmodule

bind rle_expander rle_expander_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/rle_expander_tb.sv
module rle_expander_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic       in_is_cmd_i = 1'b0;
  logic [7:0] in_byte_i = '0;
  logic       out_valid_o;
  logic       out_ready_i = 1'b0;
  logic [7:0] out_byte_o;
  logic       chan_valid_o;
  logic [6:0] chan_addr_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rle_expander u_dut (.*);

  int errors = 0, checks = 0, out_cnt = 0, rdy_pct = 100;
  logic [7:0] exp_q[$];
  bit pend_vld = 0;
  int pend_cnt = 0;
  bit exp_chan = 0;
  logic [6:0] exp_addr = '0;
  bit cur_valid = 0, cur_cmd = 0, accepted = 0;
  logic [7:0] cur_byte = '0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    bit exp_rdy;
    @(negedge clk_i);
    in_valid_i  = cur_valid;
    in_is_cmd_i = cur_cmd;
    in_byte_i   = cur_byte;
    out_ready_i = ($urandom_range(99) < rdy_pct);
    #1;
    check(chan_valid_o == exp_chan, "R6 chan_valid", chan_valid_o, exp_chan);
    if (exp_chan) check(chan_addr_o == exp_addr, "R6 chan_addr", chan_addr_o, exp_addr);
    exp_chan = 0;
    exp_rdy = (exp_q.size() == 0) || (exp_q.size() == 1 && out_ready_i);
    check(in_ready_o == exp_rdy, "R7 in_ready", in_ready_o, exp_rdy);
    check(out_valid_o == (exp_q.size() != 0), "R1 out_valid", out_valid_o, exp_q.size() != 0);
    if (out_valid_o && exp_q.size() != 0)
      check(out_byte_o == exp_q[0], "R8 out_byte", out_byte_o, exp_q[0]);
    if (out_valid_o && out_ready_i && exp_q.size() != 0) begin
      void'(exp_q.pop_front());
      out_cnt++;
    end
    accepted = in_valid_i && in_ready_o;
    if (accepted) begin
      cur_valid = 0;
      if (!in_is_cmd_i) begin
        for (int k = 0; k <= (pend_vld ? pend_cnt : 0); k++) exp_q.push_back(in_byte_i);
        pend_vld = 0;
      end else if (in_byte_i[7]) begin
        exp_chan = 1;
        exp_addr = in_byte_i[6:0];
      end else begin
        pend_vld = 1;
        pend_cnt = in_byte_i[6:0];
      end
    end
  endtask

  task automatic send(bit cmd, logic [7:0] b);
    cur_valid = 1; cur_cmd = cmd; cur_byte = b;
    for (int n = 0; n < 1000 && cur_valid; n++) step();
    if (cur_valid) check(0, "R7 input stuck", 0, 1);
    cur_valid = 0;
  endtask

  task automatic drain();
    for (int n = 0; n < 2000 && exp_q.size() != 0; n++) step();
    check(exp_q.size() == 0, "R1 drain", exp_q.size(), 0);
    step();
  endtask

  task automatic run_len(int cnt, logic [7:0] b, int exp_n, string tag);
    int start;
    start = out_cnt;
    send(1'b1, 8'(cnt));
    send(1'b0, b);
    drain();
    check(out_cnt - start == exp_n, tag, out_cnt - start, exp_n);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; in_valid_i = 0; cur_valid = 0;
    exp_q.delete(); pend_vld = 0; exp_chan = 0;
    #1;
    check(!out_valid_o, "R9 out_valid in reset", out_valid_o, 0);
    check(!chan_valid_o, "R9 chan_valid in reset", chan_valid_o, 0);
    check(in_ready_o, "R9 in_ready in reset", in_ready_o, 1);
    @(negedge clk_i);
    rst_ni = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int start;
    do_reset();
    repeat (2) step();
    run_len(5, 8'hA5, 6, "R1 count 5");
    run_len(0, 8'h3C, 1, "R2 count 0");
    run_len(127, 8'h77, 128, "R3 count 127");
    start = out_cnt;
    send(1'b0, 8'h11); drain();
    check(out_cnt - start == 1, "R4 no count", out_cnt - start, 1);
    start = out_cnt;
    send(1'b1, 8'd5); send(1'b1, 8'd2); send(1'b0, 8'h22); drain();
    check(out_cnt - start == 3, "R5 replaced count", out_cnt - start, 3);
    start = out_cnt;
    send(1'b1, 8'd3); send(1'b1, 8'h85); send(1'b0, 8'h33); drain();
    check(out_cnt - start == 4, "R6 chan keeps count", out_cnt - start, 4);
    start = out_cnt;
    send(1'b1, 8'd4); send(1'b0, 8'h44); send(1'b0, 8'h55); drain();
    check(out_cnt - start == 6, "R10 count used once", out_cnt - start, 6);
    rdy_pct = 30;
    run_len(9, 8'h66, 10, "R8 backpressure run");
    send(1'b1, 8'd20); send(1'b0, 8'h99);
    repeat (3) step();
    do_reset();
    start = out_cnt;
    send(1'b1, 8'd6);
    do_reset();
    send(1'b0, 8'hBE); drain();
    check(out_cnt - start == 1, "R9 count cleared", out_cnt - start, 1);
    rdy_pct = 70;
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(9);
      if (r < 3) send(1'b1, 8'($urandom_range(7)));
      else if (r == 3) send(1'b1, 8'h80 | 8'($urandom_range(127)));
      else send(1'b0, 8'($urandom_range(255)));
    end
    drain();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule